// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one character of up to nine bits into a serial frame on a single output line. The frame shape is picked at run time from three fields: the data length (5 to 9 bits), the parity mode (none, even or odd) and the stop count (one or two). That gives thirty valid shapes. Every frame opens with a low start bit. The data follows least significant bit first, then the optional parity bit, then the high stop bits. The line rests high between frames.

Bit timing has two sources. In asynchronous mode, each bit lasts from one baud-tick enable pulse to the next. In synchronous mode, an external shift clock is synchronised into the block's clock domain, and the line changes only on the edge chosen by the polarity select. A character is handed over through a valid/ready handshake. The format fields are captured at the moment the frame begins. A one-cycle done pulse marks the end of each frame's last stop bit. When a character is already waiting at that moment, its start bit follows the stop bit with no idle gap.

Top module: `frame_serializer`

## Requirements
- R1: After reset, and whenever no frame is in progress, the line is high, ready is high and done is low. An advance with no character waiting leaves the line high.
- R2: A frame begins with exactly one low start bit. It starts on the first advance after a character has been accepted.
- R3: Data bits follow the start bit, least significant first. The 3-bit length code maps 0→5, 1→6, 2→7, 3→8 and 7→9 bits. Codes 4, 5 and 6 give 8 bits.
- R4: The 2-bit parity code selects 0→none, 2→even, 3→odd, and 1→none. An enabled parity bit comes right after the last data bit. It makes the number of ones across the enabled data bits plus the parity bit even (code 2) or odd (code 3).
- R5: The stop field selects one stop bit (0) or two stop bits (1). Each stop bit is high.
- R6: Each bit stays on the line from one advance to the next. The line never changes without an advance.
- R7: In asynchronous mode (mode select 0), an advance is a baud-tick pulse, and shift-clock edges have no effect. In synchronous mode (mode select 1), an advance is a shift-clock rising edge when polarity is 0, or a falling edge when polarity is 1. The other edge and baud ticks have no effect.
- R8: The length, parity and stop fields are captured when the start bit is launched. Changing them during a frame does not alter that frame.
- R9: Ready is high only while idle or during the final stop bit, and only while no character is waiting. It drops in the cycle after an accepted handshake.
- R10: A character accepted during the final stop bit has its start bit launched on the advance that ends that stop bit, with no idle bit in between.
- R11: Done is a single-cycle pulse, produced by the advance that ends the final stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode_i | input | 1 | 0 = baud-tick timing, 1 = shift-clock timing |
| clk_pol_i | input | 1 | Synchronous mode: 0 = change on rising edge, 1 = on falling edge |
| baud_tick_i | input | 1 | One-cycle bit-advance enable in asynchronous mode |
| shift_clk_i | input | 1 | External shift clock, synchronised internally |
| len_code_i | input | 3 | Data length code |
| par_code_i | input | 2 | Parity mode code |
| two_stop_i | input | 1 | 0 = one stop bit, 1 = two stop bits |
| tx_data_i | input | 9 | Character to send (upper bits unused for short lengths) |
| tx_valid_i | input | 1 | Character offered |
| tx_ready_o | output | 1 | Character can be accepted |
| line_o | output | 1 | Serial output line |
| frame_done_o | output | 1 | Pulse at the end of a frame |

## Verification
The bench sweeps all eight length codes, all four parity codes and both stop counts. It does this with two complementary data words in asynchronous mode, and with one word under each shift-clock polarity. This separates the bit ordering, the reserved-code fallbacks and the even-versus-odd parity sense. Before every advance, the opposite timing source and the inactive shift-clock edge are applied, which shows whether the wrong source or edge moves the line. The format fields are scrambled after each start bit to show they were captured at launch. Frames alternate between back-to-back and closed-out, which separates gapless chaining from a return to idle.

// File: rtl/frame_ser_pkg.sv
package frame_ser_pkg;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_START,
    FS_DATA,
    FS_PAR,
    FS_STOP1,
    FS_STOP2
  } fs_state_e;

  typedef enum logic [1:0] {
    PM_NONE = 2'd0,
    PM_RSVD = 2'd1,
    PM_EVEN = 2'd2,
    PM_ODD  = 2'd3
  } par_mode_e;

  // Data length from the 3-bit length code; unlisted codes fall back to 8
  function automatic logic [3:0] len_from_code(input logic [2:0] code);
    case (code)
      3'd0:    len_from_code = 4'd5;
      3'd1:    len_from_code = 4'd6;
      3'd2:    len_from_code = 4'd7;
      3'd3:    len_from_code = 4'd8;
      3'd7:    len_from_code = 4'd9;
      default: len_from_code = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/fser_bit_strobe.sv
module fser_bit_strobe #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_mode_i,
  input  logic pol_i,
  input  logic baud_tick_i,
  input  logic shift_clk_i,
  output logic adv_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   cur;
  logic                   rise;
  logic                   fall;
  logic                   sel_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q[0] <= shift_clk_i;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sync_q[i] <= sync_q[i-1];
      end
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign cur      = sync_q[SYNC_STAGES-1];
  assign rise     = cur & ~last_q;
  assign fall     = ~cur & last_q;
  assign sel_edge = pol_i ? fall : rise;
  assign adv_o    = sync_mode_i ? sel_edge : baud_tick_i;

endmodule

// File: rtl/fser_fmt_decode.sv
module fser_fmt_decode
  import frame_ser_pkg::*;
#(
  parameter int DATA_W = 9,
  localparam int CW = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [2:0]        len_code_i,
  input  logic [1:0]        par_code_i,
  output logic [CW-1:0]     n_bits_o,
  output logic              par_en_o,
  output logic              par_bit_o
);

  logic [3:0]        raw_len;
  logic [DATA_W-1:0] mask;

  assign raw_len = len_from_code(len_code_i);

  always_comb begin
    if (32'(raw_len) > DATA_W) n_bits_o = CW'(DATA_W);
    else                       n_bits_o = CW'(raw_len);
  end

  generate
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
      assign mask[g] = (32'(n_bits_o) > g);
    end
  endgenerate

  assign par_en_o  = (par_code_i == PM_EVEN) || (par_code_i == PM_ODD);
  assign par_bit_o = (^(data_i & mask)) ^ (par_code_i == PM_ODD);

endmodule

// File: rtl/fser_sequencer.sv
module fser_sequencer
  import frame_ser_pkg::*;
#(
  parameter int DATA_W = 9,
  localparam int CW = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              two_stop_i,
  input  logic [CW-1:0]     n_bits_i,
  input  logic              par_en_i,
  input  logic              par_bit_i,
  output logic [DATA_W-1:0] hold_o,
  output logic              ready_o,
  output logic              line_o,
  output logic              done_o
);

  fs_state_e         st_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] hold_q;
  logic [CW-1:0]     cnt_q;
  logic              par_en_q;
  logic              par_bit_q;
  logic              two_q;
  logic              line_q;
  logic              done_q;
  logic              pend_q;

  logic final_stop;
  logic open_slot;
  logic do_launch;

  assign final_stop = (st_q == FS_STOP2) || ((st_q == FS_STOP1) && !two_q);
  assign open_slot  = (st_q == FS_IDLE) || final_stop;
  assign ready_o    = open_slot && !pend_q;
  assign do_launch  = adv_i && open_slot && pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= FS_IDLE;
      sh_q      <= '0;
      hold_q    <= '0;
      cnt_q     <= '0;
      par_en_q  <= 1'b0;
      par_bit_q <= 1'b0;
      two_q     <= 1'b0;
      line_q    <= 1'b1;
      done_q    <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      done_q <= adv_i && final_stop;
      if (valid_i && ready_o) begin
        pend_q <= 1'b1;
        hold_q <= data_i;
      end
      if (do_launch) begin
        st_q      <= FS_START;
        line_q    <= 1'b0;
        sh_q      <= hold_q;
        cnt_q     <= n_bits_i;
        par_en_q  <= par_en_i;
        par_bit_q <= par_bit_i;
        two_q     <= two_stop_i;
        pend_q    <= 1'b0;
      end else if (adv_i) begin
        case (st_q)
          FS_START: begin
            line_q <= sh_q[0];
            sh_q   <= sh_q >> 1;
            cnt_q  <= cnt_q - 1'b1;
            st_q   <= FS_DATA;
          end
          FS_DATA: begin
            if (cnt_q != '0) begin
              line_q <= sh_q[0];
              sh_q   <= sh_q >> 1;
              cnt_q  <= cnt_q - 1'b1;
            end else if (par_en_q) begin
              line_q <= par_bit_q;
              st_q   <= FS_PAR;
            end else begin
              line_q <= 1'b1;
              st_q   <= FS_STOP1;
            end
          end
          FS_PAR: begin
            line_q <= 1'b1;
            st_q   <= FS_STOP1;
          end
          FS_STOP1: begin
            line_q <= 1'b1;
            st_q   <= two_q ? FS_STOP2 : FS_IDLE;
          end
          FS_STOP2: begin
            line_q <= 1'b1;
            st_q   <= FS_IDLE;
          end
          default: begin
            line_q <= 1'b1;
            st_q   <= FS_IDLE;
          end
        endcase
      end
    end
  end

  assign hold_o = hold_q;
  assign line_o = line_q;
  assign done_o = done_q;

endmodule

// File: rtl/frame_serializer.sv
module frame_serializer #(
  parameter int DATA_W      = 9,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_mode_i,
  input  logic              clk_pol_i,
  input  logic              baud_tick_i,
  input  logic              shift_clk_i,
  input  logic [2:0]        len_code_i,
  input  logic [1:0]        par_code_i,
  input  logic              two_stop_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              line_o,
  output logic              frame_done_o
);

  logic              bit_adv;
  logic [DATA_W-1:0] hold_data;
  logic [CW-1:0]     n_bits;
  logic              par_en;
  logic              par_bit;

  fser_bit_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_strobe (
    .clk         (clk),
    .rst         (rst),
    .sync_mode_i (sync_mode_i),
    .pol_i       (clk_pol_i),
    .baud_tick_i (baud_tick_i),
    .shift_clk_i (shift_clk_i),
    .adv_o       (bit_adv)
  );

  fser_fmt_decode #(.DATA_W(DATA_W)) u_decode (
    .data_i     (hold_data),
    .len_code_i (len_code_i),
    .par_code_i (par_code_i),
    .n_bits_o   (n_bits),
    .par_en_o   (par_en),
    .par_bit_o  (par_bit)
  );

  fser_sequencer #(.DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .adv_i      (bit_adv),
    .valid_i    (tx_valid_i),
    .data_i     (tx_data_i),
    .two_stop_i (two_stop_i),
    .n_bits_i   (n_bits),
    .par_en_i   (par_en),
    .par_bit_i  (par_bit),
    .hold_o     (hold_data),
    .ready_o    (tx_ready_o),
    .line_o     (line_o),
    .done_o     (frame_done_o)
  );

endmodule

// File: rtl/frame_serializer_chk.sv
module frame_serializer_chk (
  input logic clk,
  input logic rst,
  input logic sync_mode_i,
  input logic baud_tick_i,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic line_o,
  input logic frame_done_o,
  input logic bit_adv
);

  // R6: without an advance the line holds its value
  a_r6_hold_without_advance: assert property (@(posedge clk) disable iff (rst)
    !bit_adv |=> $stable(line_o));

  // R7: asynchronous mode moves only on a baud tick
  a_r7_async_needs_tick: assert property (@(posedge clk) disable iff (rst)
    (!sync_mode_i && !baud_tick_i) |=> ($stable(line_o) && !frame_done_o));

  // R9: ready drops after an accepted handshake
  a_r9_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  // R9: ready only while idle or in a stop bit, both of which drive high
  a_r9_ready_line_high: assert property (@(posedge clk) disable iff (rst)
    tx_ready_o |-> line_o);

  // R11: done lasts one cycle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_done_o |=> !frame_done_o);

  // R11: done follows an advance
  a_r11_done_on_advance: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_done_o) |-> $past(bit_adv));

endmodule

bind frame_serializer frame_serializer_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .sync_mode_i  (sync_mode_i),
  .baud_tick_i  (baud_tick_i),
  .tx_valid_i   (tx_valid_i),
  .tx_ready_o   (tx_ready_o),
  .line_o       (line_o),
  .frame_done_o (frame_done_o),
  .bit_adv      (bit_adv)
);

// File: tb/frame_serializer_test.sv
module frame_serializer_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       sync_mode;
  logic       clk_pol;
  logic       baud_tick;
  logic       shift_clk;
  logic [2:0] len_code;
  logic [1:0] par_code;
  logic       two_stop;
  logic [8:0] tx_data;
  logic       tx_valid;
  logic       tx_ready;
  logic       line;
  logic       done;

  int checks = 0;
  int errors = 0;
  logic s_line, s_done, s_ready;

  always #10 clk = ~clk;

  frame_serializer uut (
    .clk          (clk),
    .rst          (rst),
    .sync_mode_i  (sync_mode),
    .clk_pol_i    (clk_pol),
    .baud_tick_i  (baud_tick),
    .shift_clk_i  (shift_clk),
    .len_code_i   (len_code),
    .par_code_i   (par_code),
    .two_stop_i   (two_stop),
    .tx_data_i    (tx_data),
    .tx_valid_i   (tx_valid),
    .tx_ready_o   (tx_ready),
    .line_o       (line),
    .frame_done_o (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=0 expected=1 (run did not finish)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // One advance; the wrong source and inactive edge are applied first (R6 R7)
  task automatic strobe();
    logic prev;
    prev = line;
    @(negedge clk);
    if (sync_mode) begin
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
      shift_clk = clk_pol;
    end else begin
      shift_clk = 1'b1;
      @(negedge clk);
      shift_clk = 1'b0;
    end
    repeat (4) @(negedge clk);
    chk(line === prev && done === 1'b0, "R6 R7 no change without active advance",
        int'(line), int'(prev));
    if (sync_mode) begin
      shift_clk = ~clk_pol;
      repeat (3) @(negedge clk);
    end else begin
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
    s_line  = line;
    s_done  = done;
    s_ready = tx_ready;
  endtask

  task automatic xmit(input logic [8:0] d, input logic [2:0] lc, input logic [1:0] pc,
                      input logic st, input bit chained);
    logic exp_bits[16];
    int   nd;
    int   nb;
    logic p;
    case (lc)
      3'd0: nd = 5;
      3'd1: nd = 6;
      3'd2: nd = 7;
      3'd7: nd = 9;
      default: nd = 8;
    endcase
    p = 1'b0;
    for (int i = 0; i < nd; i++) p = p ^ d[i];
    nb = 0;
    exp_bits[nb++] = 1'b0;
    for (int i = 0; i < nd; i++) exp_bits[nb++] = d[i];
    if (pc == 2'd2) exp_bits[nb++] = p;
    if (pc == 2'd3) exp_bits[nb++] = ~p;
    exp_bits[nb++] = 1'b1;
    if (st) exp_bits[nb++] = 1'b1;

    @(negedge clk);
    len_code = lc;
    par_code = pc;
    two_stop = st;
    tx_data  = d;
    chk(tx_ready === 1'b1, "R9 ready while idle or in final stop", int'(tx_ready), 1);
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    tx_data  = ~d;
    chk(tx_ready === 1'b0, "R9 ready low once a character waits", int'(tx_ready), 0);

    for (int k = 0; k < nb; k++) begin
      strobe();
      if (k == 0)
        chk(s_line === 1'b0, "R2 start bit low", int'(s_line), 0);
      else if (k <= nd)
        chk(s_line === exp_bits[k], "R3 data bit LSB first", int'(s_line), int'(exp_bits[k]));
      else if (pc[1] && k == nd + 1)
        chk(s_line === exp_bits[k], "R4 parity bit", int'(s_line), int'(exp_bits[k]));
      else
        chk(s_line === 1'b1, "R5 stop bit high", int'(s_line), 1);
      chk(s_ready === (k == nb - 1), "R9 ready only in final stop bit",
          int'(s_ready), int'(k == nb - 1));
      if (k == 0)
        chk(s_done === chained, "R10 R11 done on chained start", int'(s_done), int'(chained));
      else
        chk(s_done === 1'b0, "R11 no done inside frame", int'(s_done), 0);
      if (k == 0) begin
        // R8: fields scrambled mid-frame must not alter this frame
        len_code = ~lc;
        par_code = ~pc;
        two_stop = ~st;
      end
    end
  endtask

  task automatic close_out();
    strobe();
    chk(s_line === 1'b1, "R1 line high after frame", int'(s_line), 1);
    chk(s_done === 1'b1, "R11 done at end of final stop", int'(s_done), 1);
    chk(s_ready === 1'b1, "R9 ready when idle", int'(s_ready), 1);
    strobe();
    chk(s_line === 1'b1, "R1 idle advance keeps line high", int'(s_line), 1);
    chk(s_done === 1'b0, "R11 no done while idle", int'(s_done), 0);
  endtask

  initial begin
    bit open_frame;
    rst = 1'b1;
    sync_mode = 1'b0;
    clk_pol = 1'b0;
    baud_tick = 1'b0;
    shift_clk = 1'b0;
    len_code = 3'd3;
    par_code = 2'd0;
    two_stop = 1'b0;
    tx_data = 9'd0;
    tx_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(line === 1'b1, "R1 reset line high", int'(line), 1);
    chk(tx_ready === 1'b1, "R1 reset ready high", int'(tx_ready), 1);
    chk(done === 1'b0, "R1 reset done low", int'(done), 0);

    // Asynchronous sweep, two complementary words per format code
    open_frame = 1'b0;
    for (int i = 0; i < 64; i++) begin
      logic [8:0] d1;
      d1 = 9'(i * 73 + 197);
      for (int v = 0; v < 2; v++) begin
        xmit(v == 0 ? d1 : ~d1, 3'(i % 8), 2'((i / 8) % 4), 1'(i / 32), open_frame);
        open_frame = 1'b1;
        if ((i + v) % 3 == 0) begin
          close_out();
          open_frame = 1'b0;
        end
      end
    end
    if (open_frame) close_out();

    // Synchronous sweep under both polarities
    for (int pol = 0; pol < 2; pol++) begin
      @(negedge clk);
      clk_pol = 1'(pol);
      sync_mode = 1'b1;
      repeat (4) @(negedge clk);
      open_frame = 1'b0;
      for (int i = 0; i < 64; i++) begin
        xmit(9'(i * 151 + 43), 3'(i % 8), 2'((i / 8) % 4), 1'(i / 32), open_frame);
        open_frame = 1'b1;
        if (i % 3 == 1) begin
          close_out();
          open_frame = 1'b0;
        end
      end
      if (open_frame) close_out();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule